// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Validator

This block checks received Ethernet frames against their 32-bit frame check sequence. It takes one byte per clock on a data bus that has a valid qualifier and markers for the first and last byte of a frame. The bytes of a frame, including the four check bytes that close it, all pass through one 32-bit CRC register. That register is loaded with all ones at the first byte of a frame, so a frame with extra leading zero bytes gives a different result from the same frame without them.

The received check value is not extracted and compared on its own. The block relies on a property of the CRC: once the check bytes of an intact frame have passed through the register, the register holds a fixed residue. One clock after the last byte, the block raises a single-cycle completion pulse. A match flag goes high with that pulse only when the register holds that residue. Preamble removal, MAC framing and generation of the check value for transmit belong to other blocks.

Top module: `fcs_frame_checker`

## Requirements
- R1: After reset both `frame_done` and `frame_good` are low, and the CRC register holds all ones.
- R2: The register advances by one full byte on each clock where `in_valid` is high. It uses generator 0x04C11DB7 in reflected form (0xEDB88320), taking bit 0 of each byte first.
- R3: On a valid beat with `in_sof` high, the byte is folded into an all-ones value, not into the register contents.
- R4: A check value built by starting from zero and inverting the first four bytes of the frame is accepted the same as one built from an all-ones start.
- R5: A frame with two extra zero bytes in front, carrying the check value of the unpadded frame, is reported bad.
- R6: A frame is good when it ends with its check value: the complement of the CRC register after the payload, least significant byte first. Such a frame leaves residue 0xC704DD7B (0xDEBB20E3 in the reflected register), and `frame_good` is high. Any flipped bit in the payload or the check bytes makes it low.
- R7: `frame_done` is high for exactly the one clock after each valid beat with `in_eof` high. `frame_good` is never high without `frame_done`.
- R8: A valid `in_sof` in the middle of an unfinished frame drops that frame's partial result, and the new frame is judged on its own.
- R9: When `in_valid` is low the register does not change, and `in_sof` and `in_eof` have no effect.
- R10: A beat with both `in_sof` and `in_eof` high is judged as a one-byte frame.
- R11: Frames sent back to back, with no idle cycle, are each judged correctly, even though a frame's completion pulse falls on the next frame's first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid this cycle |
| in_sof | input | 1 | This byte opens a frame |
| in_eof | input | 1 | This byte closes a frame (last check byte) |
| in_data | input | 8 | Received byte |
| frame_done | output | 1 | One-cycle pulse after a frame's last byte |
| frame_good | output | 1 | With `frame_done`: residue matched |

## Verification
Two things can happen in the same clock: the verdict of one frame comes out while the first byte of the next frame is taken in and the register is preset. The bench provokes this by sending frames back to back, with a good frame directly after a bad one and the reverse. In the cycle of the next frame's first byte it checks the pulse and the flag against the first frame's expected verdict. The second frame's verdict then shows whether the restart disturbed either result. A one-byte frame with both markers on the same beat is judged the same way.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } bit_order_e;
endpackage

// File: rtl/fcs_byte_step.sv
// Folds one DATA_W-bit word into the CRC in one combinational pass.
module fcs_byte_step
   import fcs_pkg::*;
#(
   parameter int unsigned        CRC_W    = 32,
   parameter int unsigned        DATA_W   = 8,
   parameter logic [CRC_W-1:0]   POLY_INT = 32'hEDB88320,
   parameter bit_order_e         ORDER    = ORDER_LSB_FIRST
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   logic [CRC_W-1:0] chain [DATA_W+1];

   assign chain[0] = crc_in;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (ORDER == ORDER_LSB_FIRST) begin : g_refl
         logic fb;
         assign fb           = chain[i][0] ^ data_in[i];
         assign chain[i+1]   = (chain[i] >> 1) ^ (fb ? POLY_INT : '0);
      end else begin : g_norm
         logic fb;
         assign fb           = chain[i][CRC_W-1] ^ data_in[DATA_W-1-i];
         assign chain[i+1]   = (chain[i] << 1) ^ (fb ? POLY_INT : '0);
      end
   end

   assign crc_out = chain[DATA_W];
endmodule

// File: rtl/fcs_state_reg.sv
// Running CRC register with frame-start preset selection.
module fcs_state_reg #(
   parameter int unsigned      CRC_W      = 32,
   parameter logic [CRC_W-1:0] PRESET_INT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             restart,
   input  logic [CRC_W-1:0] crc_next,
   output logic [CRC_W-1:0] crc_q,
   output logic [CRC_W-1:0] seed
);
   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= PRESET_INT;
      else if (advance) crc_q <= crc_next;
   end

   assign seed = restart ? PRESET_INT : crc_q;
endmodule

// File: rtl/fcs_verdict.sv
// Registers the end-of-frame pulse and the residue comparison.
module fcs_verdict #(
   parameter int unsigned      CRC_W       = 32,
   parameter logic [CRC_W-1:0] RESIDUE_INT = 32'hDEBB20E3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close,
   input  logic [CRC_W-1:0] crc_next,
   output logic             done,
   output logic             good
);
   logic match;
   assign match = (crc_next == RESIDUE_INT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0;
         good <= 1'b0;
      end else begin
         done <= close;
         good <= close && match;
      end
   end
endmodule

// File: rtl/fcs_frame_checker.sv
module fcs_frame_checker
   import fcs_pkg::*;
#(
   parameter int unsigned      CRC_W   = 32,
   parameter int unsigned      DATA_W  = 8,
   parameter logic [CRC_W-1:0] POLY    = 32'h04C11DB7,
   parameter logic [CRC_W-1:0] PRESET  = '1,
   parameter logic [CRC_W-1:0] RESIDUE = 32'hC704DD7B,
   parameter bit_order_e       ORDER   = ORDER_LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [DATA_W-1:0] in_data,
   output logic              frame_done,
   output logic              frame_good
);
   function automatic logic [CRC_W-1:0] bitrev(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
      return r;
   endfunction

   localparam bit               REFL        = (ORDER == ORDER_LSB_FIRST);
   localparam logic [CRC_W-1:0] POLY_INT    = REFL ? bitrev(POLY)    : POLY;
   localparam logic [CRC_W-1:0] PRESET_INT  = REFL ? bitrev(PRESET)  : PRESET;
   localparam logic [CRC_W-1:0] RESIDUE_INT = REFL ? bitrev(RESIDUE) : RESIDUE;

   if (CRC_W < 8 || CRC_W > 64) begin : g_bad_width
      $error("fcs_frame_checker: CRC_W must lie in 8..64");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
      $error("fcs_frame_checker: DATA_W must lie in 1..64");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("fcs_frame_checker: generator needs its constant term");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] seed;
   logic [CRC_W-1:0] crc_next;
   logic             close;

   assign close = in_valid && in_eof;

   fcs_state_reg #(.CRC_W(CRC_W), .PRESET_INT(PRESET_INT)) u_state (
      .clk(clk), .rst_n(rst_n), .advance(in_valid), .restart(in_sof),
      .crc_next(crc_next), .crc_q(crc_q), .seed(seed)
   );

   fcs_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY_INT(POLY_INT),
                   .ORDER(ORDER)) u_step (
      .crc_in(seed), .data_in(in_data), .crc_out(crc_next)
   );

   fcs_verdict #(.CRC_W(CRC_W), .RESIDUE_INT(RESIDUE_INT)) u_verdict (
      .clk(clk), .rst_n(rst_n), .close(close), .crc_next(crc_next),
      .done(frame_done), .good(frame_good)
   );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
   parameter int unsigned CRC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_eof,
   input logic             frame_done,
   input logic             frame_good,
   input logic [CRC_W-1:0] crc_state
);
   p_good_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_good |-> frame_done);

   p_eof_yields_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> frame_done);

   p_done_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(in_valid && in_eof));

   p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(crc_state));
endmodule

bind fcs_frame_checker fcs_checker #(.CRC_W(CRC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
   .frame_done(frame_done), .frame_good(frame_good), .crc_state(crc_q)
);

// File: tb/sim_fcs_frame_checker.sv
module sim_fcs_frame_checker;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam logic [31:0] RPOLY = 32'hEDB88320;
   localparam logic [31:0] RRES  = 32'hDEBB20E3;
   // {payload length, seed, mode, expected good}
   // mode 0 intact, 1 payload bit flip, 2 check byte flip, 3 two zero bytes prepended
   localparam int NV = 8;
   localparam logic [18:0] VEC [NV] = '{
      {8'd20, 8'h11, 2'd0, 1'b1},
      {8'd1,  8'h9C, 2'd0, 1'b1},
      {8'd46, 8'h3C, 2'd0, 1'b1},
      {8'd12, 8'h55, 2'd1, 1'b0},
      {8'd30, 8'hA7, 2'd2, 1'b0},
      {8'd9,  8'h00, 2'd3, 1'b0},
      {8'd60, 8'hF0, 2'd0, 1'b1},
      {8'd4,  8'h00, 2'd0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic frame_done, frame_good;

   int checks = 0, fails = 0;
   logic [7:0] frm [0:79];
   bit    prev_close = 1'b0, prev_exp = 1'b0;
   string prev_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   fcs_frame_checker u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data),
      .frame_done(frame_done), .frame_good(frame_good)
   );

   function automatic logic [31:0] ref_crc(int start, int cnt, logic [31:0] init, int invn);
      logic [31:0] c = init;
      for (int i = 0; i < cnt; i++) begin
         logic [7:0] b = frm[start+i];
         if (i < invn) b = ~b;
         c = c ^ {24'h0, b};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ RPOLY) : (c >> 1);
      end
      return c;
   endfunction

   function automatic int build(int len, logic [7:0] seed, int off);
      logic [31:0] fcs;
      for (int i = 0; i < off; i++) frm[i] = 8'h00;
      for (int i = 0; i < len; i++) frm[off+i] = 8'(seed + 8'(i * 29));
      fcs = ~ref_crc(off, len, 32'hFFFFFFFF, 0);
      for (int k = 0; k < 4; k++) frm[off+len+k] = fcs[8*k +: 8];
      return off + len + 4;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One clock: judge the previous beat's outcome, then drive this beat.
   task automatic beat(bit v, bit s, bit e, logic [7:0] d, bit x, string rq);
      @(negedge clk);
      chk(frame_done === prev_close, prev_req, "frame_done", int'(frame_done), int'(prev_close));
      chk(frame_good === (prev_close && prev_exp), prev_req, "frame_good",
          int'(frame_good), int'(prev_close && prev_exp));
      in_valid = v; in_sof = s; in_eof = e; in_data = d;
      prev_close = v && e; prev_exp = x; prev_req = rq;
   endtask

   task automatic send(int total, bit gaps, bit x, string rq);
      for (int i = 0; i < total; i++) begin
         if (gaps && (i % 3 == 2)) beat(1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, rq);
         beat(1'b1, i == 0, i == total - 1, frm[i], x, rq);
      end
   endtask

   task automatic idle(string rq);
      beat(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, rq);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: outputs low out of reset
      idle("R1");
      idle("R1");

      // R2 R6 R5 R9: table of frames; odd entries carry idle noise beats
      for (int t = 0; t < NV; t++) begin
         logic [18:0] v = VEC[t];
         int off = (v[2:1] == 2'd3) ? 2 : 0;
         n = build(int'(v[18:11]), v[10:3], off);
         if (v[2:1] == 2'd1) frm[int'(v[18:11]) / 2] ^= 8'h04;
         if (v[2:1] == 2'd2) frm[off + int'(v[18:11]) + 1] ^= 8'h80;
         send(n, t[0], v[0], (v[2:1] == 2'd3) ? "R5" : (t[0] ? "R6 R9" : "R2 R6"));
         idle("R6");
      end

      // R4: check value from zero start with first four bytes inverted
      begin
         logic [31:0] fz;
         n = build(10, 8'h77, 0);
         fz = ~ref_crc(0, 10, 32'h0, 4);
         for (int k = 0; k < 4; k++) frm[10+k] = fz[8*k +: 8];
         send(n, 1'b0, 1'b1, "R4");
         idle("R4");
      end

      // R8: unfinished frame, then a new start
      n = build(16, 8'h21, 0);
      for (int i = 0; i < 6; i++) beat(1'b1, i == 0, 1'b0, 8'hC3 ^ 8'(i), 1'b0, "R8");
      send(n, 1'b0, 1'b1, "R8 R3");
      idle("R8");

      // R10: single beat with both markers, then a good frame
      frm[0] = 8'h5A;
      beat(1'b1, 1'b1, 1'b1, 8'h5A, ref_crc(0, 1, 32'hFFFFFFFF, 0) == RRES, "R10");
      n = build(7, 8'h42, 0);
      send(n, 1'b0, 1'b1, "R10 R3");
      idle("R10");

      // R11: back to back: bad, good, good, bad
      n = build(8, 8'h13, 0); frm[3] ^= 8'h10; send(n, 1'b0, 1'b0, "R11");
      n = build(5, 8'h88, 0); send(n, 1'b0, 1'b1, "R11");
      n = build(25, 8'h6D, 0); send(n, 1'b0, 1'b1, "R11");
      n = build(3, 8'hE1, 0); frm[n-1] ^= 8'h01; send(n, 1'b0, 1'b0, "R11");
      idle("R11");
      idle("R7");

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule